// File: doc/BRIEF.md
# Segment Address Translation Unit

This block maps a 16-bit virtual address onto a physical address through a table of four segment entries. The two most significant address bits pick an entry. The remaining fourteen bits form an offset. Each entry holds a base, a limit (the segment length), a valid flag and a read-only flag.

A request is presented for one cycle, together with a load/store indication. One cycle later the block returns either the physical address (base plus offset) or a classified access error. A privileged write port loads the entries. Writes made without privilege leave the table untouched.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset every entry is invalid, so any request returns error code 2. No response is presented until a request arrives.
- R2: Virtual address bits 15:14 select the entry and bits 13:0 are the offset. The offset is used at its full 14-bit width.
- R3: A request sampled on one clock edge yields rsp_valid_o on the next edge, with no gaps for back-to-back requests. The physical address is base plus offset, modulo 2^16.
- R4: An offset that is greater than or equal to the entry's limit returns error code 1 (bounds).
- R5: A request to an entry whose valid flag is clear returns error code 2 (invalid). This code wins over the bounds and write-protection checks.
- R6: A store to an entry marked read-only returns error code 3 (write protect). A load to such an entry translates normally. A bounds violation is reported as code 1 rather than code 3.
- R7: Whenever the error code is nonzero, the returned physical address is 0.
- R8: A table write with cfg_priv_i low is ignored. A write with cfg_priv_i high replaces the selected entry's base, limit, valid flag and read-only flag.
- R9: With the entries loaded as follows, virtual 0x0240 maps to 0x4240 and virtual 0x4050 maps to 0x4850:

  | Entry | Base | Limit |
  |-------|------|-------|
  | 0 | 0x4000 | 0x0800 |
  | 1 | 0x4800 | 0x1400 |
  | 2 | 0xF000 | 0x1000 |
  | 3 | 0x0000 | 0x3000 |

- R10: In a cycle where rsp_valid_o is low, rsp_paddr_o and rsp_err_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request strobe |
| req_vaddr_i | input | 16 | Virtual address |
| req_store_i | input | 1 | 1 = store access, 0 = load access |
| rsp_valid_o | output | 1 | Result valid, one cycle after the request |
| rsp_paddr_o | output | 16 | Physical address (0 on error) |
| rsp_err_o | output | 2 | Error code: 0 none, 1 bounds, 2 invalid, 3 write protect |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_priv_i | input | 1 | Privileged mode; a write takes effect only when this is high |
| cfg_idx_i | input | 2 | Entry to write |
| cfg_base_i | input | 16 | New base |
| cfg_limit_i | input | 15 | New limit (segment length, up to 0x4000) |
| cfg_valid_i | input | 1 | New valid flag |
| cfg_ro_i | input | 1 | New read-only flag |

## Verification
The hardest situations to reach are those where several faults coincide on one request. Examples are an out-of-range store to a read-only entry, or an out-of-range store to an invalid entry. Only these cases show whether the error priority is right. The stimulus reprograms entries through the privileged port into those combinations. It also sets a base near the top of the address space, so that base plus offset wraps past 2^16. Unprivileged writes are interleaved and followed by translations, so any leak into the table would change the results.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    XERR_NONE    = 2'd0,
    XERR_BOUNDS  = 2'd1,
    XERR_INVALID = 2'd2,
    XERR_WPROT   = 2'd3
  } xerr_e;
endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int unsigned SEG_BITS = 2,
  parameter int unsigned PA_W     = 16,
  parameter int unsigned LIM_W    = 15,
  localparam int unsigned N_SEG   = 1 << SEG_BITS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic                priv_i,
  input  logic [SEG_BITS-1:0] wr_idx_i,
  input  logic [PA_W-1:0]     wr_base_i,
  input  logic [LIM_W-1:0]    wr_limit_i,
  input  logic                wr_valid_i,
  input  logic                wr_ro_i,
  input  logic [SEG_BITS-1:0] rd_idx_i,
  output logic [PA_W-1:0]     rd_base_o,
  output logic [LIM_W-1:0]    rd_limit_o,
  output logic                rd_valid_o,
  output logic                rd_ro_o
);
  logic [PA_W-1:0]  base_q  [N_SEG];
  logic [LIM_W-1:0] limit_q [N_SEG];
  logic [N_SEG-1:0] valid_q;
  logic [N_SEG-1:0] ro_q;

  for (genvar g = 0; g < N_SEG; g++) begin : g_ent
    logic hit;
    assign hit = we_i && priv_i && (wr_idx_i == SEG_BITS'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[g]  <= '0;
        limit_q[g] <= '0;
        valid_q[g] <= 1'b0;
        ro_q[g]    <= 1'b0;
      end else if (hit) begin
        base_q[g]  <= wr_base_i;
        limit_q[g] <= wr_limit_i;
        valid_q[g] <= wr_valid_i;
        ro_q[g]    <= wr_ro_i;
      end
    end

    assert_unpriv_write_ignored_R8: assert property (
      @(posedge clk_i) disable iff (!rst_ni)
      (we_i && !priv_i) |=> ($stable(base_q[g]) && $stable(limit_q[g])
                             && $stable(valid_q[g]) && $stable(ro_q[g])));
  end

  assign rd_base_o  = base_q[rd_idx_i];
  assign rd_limit_o = limit_q[rd_idx_i];
  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_ro_o    = ro_q[rd_idx_i];
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int unsigned OFF_W = 14,
  parameter int unsigned PA_W  = 16,
  parameter int unsigned LIM_W = 15
) (
  input  logic [OFF_W-1:0] offset_i,
  input  logic             store_i,
  input  logic [PA_W-1:0]  base_i,
  input  logic [LIM_W-1:0] limit_i,
  input  logic             valid_i,
  input  logic             ro_i,
  output logic [PA_W-1:0]  paddr_o,
  output xerr_e            err_o
);
  logic [LIM_W-1:0] off_ext;
  logic [PA_W-1:0]  sum;

  assign off_ext = LIM_W'(offset_i);
  assign sum     = base_i + PA_W'(offset_i);

  // priority: invalid, then bounds, then write protect
  always_comb begin
    if (!valid_i)                 err_o = XERR_INVALID;
    else if (off_ext >= limit_i)  err_o = XERR_BOUNDS;
    else if (store_i && ro_i)     err_o = XERR_WPROT;
    else                          err_o = XERR_NONE;
  end

  assign paddr_o = (err_o == XERR_NONE) ? sum : '0;
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int unsigned VA_W     = 16,
  parameter int unsigned SEG_BITS = 2,
  parameter int unsigned PA_W     = 16,
  localparam int unsigned OFF_W   = VA_W - SEG_BITS,
  localparam int unsigned LIM_W   = OFF_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [VA_W-1:0]     req_vaddr_i,
  input  logic                req_store_i,
  output logic                rsp_valid_o,
  output logic [PA_W-1:0]     rsp_paddr_o,
  output logic [1:0]          rsp_err_o,
  input  logic                cfg_we_i,
  input  logic                cfg_priv_i,
  input  logic [SEG_BITS-1:0] cfg_idx_i,
  input  logic [PA_W-1:0]     cfg_base_i,
  input  logic [LIM_W-1:0]    cfg_limit_i,
  input  logic                cfg_valid_i,
  input  logic                cfg_ro_i
);
  logic [SEG_BITS-1:0] seg;
  logic [OFF_W-1:0]    off;
  logic [PA_W-1:0]     ent_base;
  logic [LIM_W-1:0]    ent_limit;
  logic                ent_valid, ent_ro;
  logic [PA_W-1:0]     chk_paddr;
  xerr_e               chk_err;

  assign seg = req_vaddr_i[VA_W-1 -: SEG_BITS];
  assign off = req_vaddr_i[OFF_W-1:0];

  seg_table #(.SEG_BITS(SEG_BITS), .PA_W(PA_W), .LIM_W(LIM_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .priv_i     (cfg_priv_i),
    .wr_idx_i   (cfg_idx_i),
    .wr_base_i  (cfg_base_i),
    .wr_limit_i (cfg_limit_i),
    .wr_valid_i (cfg_valid_i),
    .wr_ro_i    (cfg_ro_i),
    .rd_idx_i   (seg),
    .rd_base_o  (ent_base),
    .rd_limit_o (ent_limit),
    .rd_valid_o (ent_valid),
    .rd_ro_o    (ent_ro)
  );

  seg_check #(.OFF_W(OFF_W), .PA_W(PA_W), .LIM_W(LIM_W)) u_check (
    .offset_i (off),
    .store_i  (req_store_i),
    .base_i   (ent_base),
    .limit_i  (ent_limit),
    .valid_i  (ent_valid),
    .ro_i     (ent_ro),
    .paddr_o  (chk_paddr),
    .err_o    (chk_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_paddr_o <= '0;
      rsp_err_o   <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_paddr_o <= req_valid_i ? chk_paddr : '0;
      rsp_err_o   <= req_valid_i ? chk_err : '0;
    end
  end

  assert_rsp_follows_req_R3: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  assert_no_spurious_rsp_R3: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  assert_invalid_wins_R5: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !ent_valid) |=> (rsp_err_o == 2'd2));

  assert_bounds_flag_R4: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ent_valid && (LIM_W'(off) >= ent_limit)) |=> (rsp_err_o == 2'd1));

  assert_err_zero_addr_R7: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (rsp_err_o != 2'd0) |-> (rsp_paddr_o == '0));

  assert_idle_quiet_R10: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (rsp_paddr_o == '0 && rsp_err_o == 2'd0));
endmodule

// File: tb/sim_seg_xlate_unit.sv
module sim_seg_xlate_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_vaddr = '0;
  logic        req_store = 1'b0;
  logic        rsp_valid;
  logic [15:0] rsp_paddr;
  logic [1:0]  rsp_err;
  logic        cfg_we = 1'b0, cfg_priv = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [15:0] cfg_base = '0;
  logic [14:0] cfg_limit = '0;
  logic        cfg_valid = 1'b0, cfg_ro = 1'b0;

  always #5 clk = ~clk;

  seg_xlate_unit u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .req_store_i(req_store),
    .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr), .rsp_err_o(rsp_err),
    .cfg_we_i(cfg_we), .cfg_priv_i(cfg_priv), .cfg_idx_i(cfg_idx),
    .cfg_base_i(cfg_base), .cfg_limit_i(cfg_limit),
    .cfg_valid_i(cfg_valid), .cfg_ro_i(cfg_ro)
  );

  typedef struct {
    logic [15:0] paddr;
    logic [1:0]  err;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_fail = 0, cyc = 0;

  // shadow table, updated per R8
  logic [15:0] sb [4];
  logic [14:0] sl [4];
  logic [3:0]  sv = '0, sro = '0;

  function automatic exp_t model(input logic [15:0] va, input logic st, input string tag);
    exp_t e;
    int s;
    logic [14:0] o;
    s = int'(va[15:14]);
    o = {1'b0, va[13:0]};
    e.tag = tag;
    if (!sv[s])                e.err = 2'd2;
    else if (o >= sl[s])       e.err = 2'd1;
    else if (st && sro[s])     e.err = 2'd3;
    else                       e.err = 2'd0;
    e.paddr = (e.err == 2'd0) ? sb[s] + {2'b00, va[13:0]} : 16'h0;
    return e;
  endfunction

  task automatic cfg(input int idx, input logic [15:0] b, input logic [14:0] l,
                     input logic v, input logic ro, input logic priv);
    @(negedge clk);
    cfg_we = 1'b1; cfg_priv = priv; cfg_idx = idx[1:0];
    cfg_base = b; cfg_limit = l; cfg_valid = v; cfg_ro = ro;
    if (priv) begin sb[idx] = b; sl[idx] = l; sv[idx] = v; sro[idx] = ro; end
    @(negedge clk);
    cfg_we = 1'b0; cfg_priv = 1'b0;
  endtask

  task automatic issue(input logic [15:0] va, input logic st, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_store = st;
    exp_q.push_back(model(va, st, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; req_store = 1'b0;
  endtask

  task automatic xlate(input logic [15:0] va, input logic st, input string tag);
    issue(va, st, tag);
    idle();
  endtask

  task automatic check_idle(input string tag);
    @(negedge clk);
    n_chk++;
    if (rsp_valid !== 1'b0 || rsp_paddr !== 16'h0 || rsp_err !== 2'd0) begin
      n_fail++;
      $display("FAIL %s: idle valid=%0b paddr=%h err=%0d expected 0/0000/0",
               tag, rsp_valid, rsp_paddr, rsp_err);
    end
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #2;
    if (rst_n && rsp_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R3: unexpected response paddr=%h err=%0d expected none", rsp_paddr, rsp_err);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (rsp_paddr !== e.paddr || rsp_err !== e.err) begin
          n_fail++;
          $display("FAIL %s: paddr=%h err=%0d expected paddr=%h err=%0d",
                   e.tag, rsp_paddr, rsp_err, e.paddr, e.err);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin sb[i] = '0; sl[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_idle("R1 reset");
    xlate(16'h0240, 1'b0, "R1 all invalid after reset");

    // unprivileged write ignored
    cfg(0, 16'h4000, 15'h0800, 1'b1, 1'b0, 1'b0);
    xlate(16'h0240, 1'b0, "R8 unpriv write ignored");

    // reference configuration, entry 0 read-only
    cfg(0, 16'h4000, 15'h0800, 1'b1, 1'b1, 1'b1);
    cfg(1, 16'h4800, 15'h1400, 1'b1, 1'b0, 1'b1);
    cfg(2, 16'hF000, 15'h1000, 1'b1, 1'b0, 1'b1);
    cfg(3, 16'h0000, 15'h3000, 1'b1, 1'b0, 1'b1);
    xlate(16'h0240, 1'b0, "R9 0x0240");
    xlate(16'h4050, 1'b0, "R9 0x4050");
    xlate(16'h07FF, 1'b0, "R4 last in range seg0");
    xlate(16'h0800, 1'b0, "R4 offset==limit seg0");
    xlate(16'h53FF, 1'b0, "R2 seg1 top offset");
    xlate(16'h5400, 1'b0, "R4 seg1 bounds");
    xlate(16'h8FFF, 1'b0, "R3 seg2 to 0xFFFF");
    xlate(16'h9000, 1'b0, "R4 seg2 bounds");
    xlate(16'hC000, 1'b0, "R3 seg3 address zero no error");
    xlate(16'hEFFF, 1'b0, "R2 seg3 last");
    xlate(16'hF000, 1'b1, "R4 seg3 bounds store");
    xlate(16'h0240, 1'b1, "R6 store to read-only");
    xlate(16'h4240, 1'b1, "R6 store to writable");
    xlate(16'h0900, 1'b1, "R6 bounds beats write protect");
    check_idle("R10 idle after traffic");

    // invalid wins over all
    cfg(3, 16'h1000, 15'h0100, 1'b0, 1'b1, 1'b1);
    xlate(16'hC010, 1'b0, "R5 invalid in range");
    xlate(16'hFFFF, 1'b1, "R5 invalid beats bounds and wprot");
    cfg(3, 16'h2000, 15'h4000, 1'b1, 1'b0, 1'b0);
    xlate(16'hC010, 1'b0, "R8 unpriv re-enable ignored");

    // wrap and full-length segment
    cfg(1, 16'hFFF0, 15'h4000, 1'b1, 1'b0, 1'b1);
    xlate(16'h4020, 1'b1, "R3 base plus offset wraps");
    xlate(16'h7FFF, 1'b0, "R2 full offset limit 0x4000");

    // back-to-back
    issue(16'h0010, 1'b0, "R3 b2b 0");
    issue(16'h4010, 1'b1, "R3 b2b 1");
    issue(16'h0011, 1'b1, "R3 b2b 2");
    issue(16'h8001, 1'b0, "R3 b2b 3");
    idle();
    repeat (3) @(negedge clk);
    check_idle("R10 idle after burst");

    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R3: %0d responses missing, expected 0", exp_q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule